// File: doc/BRIEF.md
# Receive FIFO DMA Watermark Controller

This block decides when the receive path asks the bus DMA engine to start moving a frame out of the receive FIFO. It watches the current FIFO occupancy and a per-frame byte strobe, and raises a request level once the frame has received enough bytes to rule out a runt and the FIFO holds at least the number of bytes selected by a 2-bit watermark field.

In half-duplex operation a frame must first deliver one full collision slot of 64 bytes (512 bit times) before any request, whatever the watermark says. In full-duplex operation there are no collisions, so a frame counts as qualified from its first cycle. An optional runt-accept mode adds a second way to raise the request: a valid-frame-complete strobe raises it at once, whatever the frame's length. Once raised, the request stays up until the frame has completed and the FIFO has drained to empty.

The watermark sits in a small host register. Software may change it only while the receive side is stopped or suspended. The two bits above it always read as ones.

Top module: `rx_dma_watermark`

## Requirements
- R1: After a synchronous reset, dma_req is 0, the watermark field is 10b, and cfg_rd_data reads 4'b1110.
- R2: A write with cfg_wr_en high updates the watermark from cfg_wr_data[1:0] in the next cycle only when ctrl_halted is high. When ctrl_halted is low the write is ignored and cfg_rd_data does not change.
- R3: cfg_rd_data[3:2] always reads 2'b11, whatever value was written.
- R4: The watermark encoding is 00b = 16, 01b = 32, 10b = 64 and 11b = 112 bytes. For an active, qualified frame, dma_req rises in the cycle after fifo_count first reaches at least the selected value, and stays low while fifo_count is below it.
- R5: With full_duplex low, no request is raised for a frame until 64 rx_byte strobes have been counted since its frame_start. The request follows one cycle after the cycle in which the 64th count is held, even if the watermark was met earlier.
- R6: With full_duplex high, a frame is qualified from frame_start, so only the watermark condition gates the request.
- R7: With runt_accept high, a frame_done_ok strobe (without frame_start in the same cycle) raises dma_req in the next cycle, whatever the number of bytes received.
- R8: With runt_accept low, frame_done_ok raises dma_req only for a qualified frame. An unqualified (runt) frame completes with dma_req staying low.
- R9: Once high, dma_req stays high until the frame has completed and fifo_count is 0. It falls in the cycle after that condition is seen.
- R10: frame_start clears the per-frame byte count, the qualification and the completion flag. When frame_start and frame_done_ok come in the same cycle, the start wins and no completion is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_count | input | CNT_W | Bytes currently held in the receive FIFO |
| rx_byte | input | 1 | One received byte of the current frame written to the FIFO this cycle |
| frame_start | input | 1 | Strobe: a new frame begins |
| frame_done_ok | input | 1 | Strobe: the current frame completed and is valid |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| runt_accept | input | 1 | Enables the request on frame completion, whatever the length |
| ctrl_halted | input | 1 | Receive side is stopped or suspended; unlocks register writes |
| cfg_wr_en | input | 1 | Host write strobe for the watermark register |
| cfg_wr_data | input | 4 | Host write data; bits [1:0] are the watermark |
| cfg_rd_data | output | 4 | Register read data: {2'b11, watermark} |
| dma_req | output | 1 | Registered receive DMA request level |

## Verification
Two functions can act in the same cycle:
- the watermark crossing and the completion strobe, with runt accept on or off;
- the release condition (frame completed and FIFO empty) and a new completion or a frame start.

The bench provokes these with directed cycles that line fifo_count up against the threshold in the very cycle frame_done_ok or frame_start pulses. It adds seeded random traffic that toggles the strobes and drains the FIFO after completion. Each cycle, dma_req and cfg_rd_data are compared with a cycle model written from the requirements. In that model, a set takes priority over the release and a start overrides a completion.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;

  typedef enum logic [1:0] {
    WM_16  = 2'b00,
    WM_32  = 2'b01,
    WM_64  = 2'b10,
    WM_112 = 2'b11
  } wm_sel_e;

  localparam logic [1:0] WM_RESET = 2'b10;
  localparam int unsigned SLOT_BYTES_DEF = 64;

  function automatic int unsigned wm_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 16;
      2'b01:   return 32;
      2'b10:   return 64;
      default: return 112;
    endcase
  endfunction

endpackage

// File: rtl/rxwm_cfg_reg.sv
module rxwm_cfg_reg
  import rxwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       halted,
  input  logic [3:0] wdata,
  output logic [1:0] wm_sel,
  output logic [3:0] rd_data
);

  logic [1:0] wm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wm_q <= WM_RESET;
    end else if (wr_en && halted) begin
      wm_q <= wdata[1:0];
    end
  end

  assign wm_sel  = wm_q;
  assign rd_data = {2'b11, wm_q};

endmodule

// File: rtl/rxwm_frame_track.sv
module rxwm_frame_track #(
  parameter int unsigned SLOT_BYTES = 64,
  localparam int unsigned BC_W = $clog2(SLOT_BYTES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic frame_done,
  input  logic rx_byte,
  input  logic full_duplex,
  output logic qualified,
  output logic done
);

  localparam logic [BC_W-1:0] SLOT_CNT = BC_W'(SLOT_BYTES);

  logic [BC_W-1:0] byte_cnt;
  logic            done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_cnt <= '0;
    end else if (frame_start) begin
      byte_cnt <= '0;
    end else if (rx_byte && (byte_cnt != SLOT_CNT)) begin
      byte_cnt <= byte_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
    end else if (frame_start) begin
      done_q <= 1'b0;
    end else if (frame_done) begin
      done_q <= 1'b1;
    end
  end

  assign qualified = full_duplex || (byte_cnt == SLOT_CNT);
  assign done      = done_q;

endmodule

// File: rtl/rxwm_req_gen.sv
module rxwm_req_gen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] threshold,
  input  logic             qualified,
  input  logic             done,
  input  logic             frame_start,
  input  logic             frame_done,
  input  logic             runt_accept,
  output logic             dma_req
);

  logic req_q;
  logic set_wm;
  logic set_fin;
  logic release_now;

  always_comb begin
    set_wm      = !frame_start && !done && qualified && (fifo_count >= threshold);
    set_fin     = !frame_start && frame_done && (runt_accept || qualified);
    release_now = done && (fifo_count == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else if (set_wm || set_fin) begin
      req_q <= 1'b1;
    end else if (release_now) begin
      req_q <= 1'b0;
    end
  end

  assign dma_req = req_q;

endmodule

// File: rtl/rx_dma_watermark.sv
module rx_dma_watermark
  import rxwm_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned SLOT_BYTES = SLOT_BYTES_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             rx_byte,
  input  logic             frame_start,
  input  logic             frame_done_ok,
  input  logic             full_duplex,
  input  logic             runt_accept,
  input  logic             ctrl_halted,
  input  logic             cfg_wr_en,
  input  logic [3:0]       cfg_wr_data,
  output logic [3:0]       cfg_rd_data,
  output logic             dma_req
);

  logic [1:0]       wm_sel;
  logic [CNT_W-1:0] threshold;
  logic             qualified;
  logic             done;

  rxwm_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .halted  (ctrl_halted),
    .wdata   (cfg_wr_data),
    .wm_sel  (wm_sel),
    .rd_data (cfg_rd_data)
  );

  assign threshold = CNT_W'(wm_bytes(wm_sel));

  rxwm_frame_track #(.SLOT_BYTES(SLOT_BYTES)) u_trk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .frame_done  (frame_done_ok),
    .rx_byte     (rx_byte),
    .full_duplex (full_duplex),
    .qualified   (qualified),
    .done        (done)
  );

  rxwm_req_gen #(.CNT_W(CNT_W)) u_req (
    .clk         (clk),
    .rst         (rst),
    .fifo_count  (fifo_count),
    .threshold   (threshold),
    .qualified   (qualified),
    .done        (done),
    .frame_start (frame_start),
    .frame_done  (frame_done_ok),
    .runt_accept (runt_accept),
    .dma_req     (dma_req)
  );

endmodule

// File: rtl/rxwm_checker.sv
module rxwm_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] fifo_count,
  input logic             rx_byte,
  input logic             frame_start,
  input logic             frame_done_ok,
  input logic             full_duplex,
  input logic             runt_accept,
  input logic             ctrl_halted,
  input logic             cfg_wr_en,
  input logic [3:0]       cfg_wr_data,
  input logic [3:0]       cfg_rd_data,
  input logic             dma_req
);

  logic [7:0] chk_bytes;
  logic       chk_done;

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      chk_bytes <= '0;
    end else if (rx_byte && chk_bytes != 8'hFF) begin
      chk_bytes <= chk_bytes + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || frame_start) chk_done <= 1'b0;
    else if (frame_done_ok) chk_done <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !dma_req); // R1

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && !ctrl_halted) |=> $stable(cfg_rd_data)); // R2

  AST_RSV_ONES: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_data[3:2] == 2'b11); // R3

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($rose(dma_req) && !$past(full_duplex) && !$past(runt_accept)) |-> (chk_bytes >= 8'd64)); // R5

  AST_RUNT_FIN: assert property (@(posedge clk) disable iff (rst)
    (runt_accept && frame_done_ok && !frame_start) |=> dma_req); // R7

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (dma_req && chk_done && fifo_count == '0 && !frame_done_ok && !frame_start) |=> !dma_req); // R9

endmodule

bind rx_dma_watermark rxwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fifo_count    (fifo_count),
  .rx_byte       (rx_byte),
  .frame_start   (frame_start),
  .frame_done_ok (frame_done_ok),
  .full_duplex   (full_duplex),
  .runt_accept   (runt_accept),
  .ctrl_halted   (ctrl_halted),
  .cfg_wr_en     (cfg_wr_en),
  .cfg_wr_data   (cfg_wr_data),
  .cfg_rd_data   (cfg_rd_data),
  .dma_req       (dma_req)
);

// File: tb/rx_dma_watermark_tb.sv
module rx_dma_watermark_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] fifo_count = '0;
  logic             rx_byte = 1'b0;
  logic             frame_start = 1'b0;
  logic             frame_done_ok = 1'b0;
  logic             full_duplex = 1'b0;
  logic             runt_accept = 1'b0;
  logic             ctrl_halted = 1'b0;
  logic             cfg_wr_en = 1'b0;
  logic [3:0]       cfg_wr_data = '0;
  logic [3:0]       cfg_rd_data;
  logic             dma_req;

  int checks = 0;
  int fails  = 0;

  logic [1:0] m_wm;
  int         m_cnt;
  logic       m_done;
  logic       m_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dma_watermark #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .fifo_count(fifo_count), .rx_byte(rx_byte),
    .frame_start(frame_start), .frame_done_ok(frame_done_ok),
    .full_duplex(full_duplex), .runt_accept(runt_accept),
    .ctrl_halted(ctrl_halted), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .dma_req(dma_req)
  );

  function automatic int thr_of(input logic [1:0] s);
    case (s)
      2'b00: return 16;
      2'b01: return 32;
      2'b10: return 64;
      default: return 112;
    endcase
  endfunction

  task automatic model_step();
    logic qual, set_any, rel;
    if (rst) begin
      m_wm = 2'b10; m_cnt = 0; m_done = 1'b0; m_req = 1'b0;
      return;
    end
    qual    = full_duplex || (m_cnt >= 64);
    set_any = (!frame_start && !m_done && qual && (int'(fifo_count) >= thr_of(m_wm))) ||
              (!frame_start && frame_done_ok && (runt_accept || qual));
    rel     = m_done && (fifo_count == 0);
    if (set_any) m_req = 1'b1;
    else if (rel) m_req = 1'b0;
    if (frame_start) begin m_cnt = 0; m_done = 1'b0; end
    else begin
      if (rx_byte && m_cnt < 64) m_cnt++;
      if (frame_done_ok) m_done = 1'b1;
    end
    if (cfg_wr_en && ctrl_halted) m_wm = cfg_wr_data[1:0];
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    #1;
    checks++;
    if (dma_req !== m_req) begin
      fails++;
      $display("FAIL %s dma_req actual=%0b expected=%0b t=%0t", tag, dma_req, m_req, $time);
    end
    checks++;
    if (cfg_rd_data !== {2'b11, m_wm}) begin
      fails++;
      $display("FAIL %s cfg_rd_data actual=%b expected=%b t=%0t", tag, cfg_rd_data, {2'b11, m_wm}, $time);
    end
  endtask

  task automatic idle();
    frame_start = 0; frame_done_ok = 0; rx_byte = 0; cfg_wr_en = 0;
  endtask

  task automatic write_wm(input logic [1:0] v, input string tag);
    ctrl_halted = 1; cfg_wr_en = 1; cfg_wr_data = {2'b00, v};
    tick(tag);
    cfg_wr_en = 0; ctrl_halted = 0;
  endtask

  task automatic drain(input string tag);
    idle(); fifo_count = 0;
    tick(tag); tick(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1;
    tick("R1"); tick("R1");
    rst = 0;
    tick("R1");

    // R2 / R3: locked write then unlocked write
    cfg_wr_en = 1; cfg_wr_data = 4'b0001; ctrl_halted = 0;
    tick("R2"); tick("R2");
    write_wm(2'b11, "R2");
    tick("R3");
    cfg_wr_data = 4'b0000;
    write_wm(2'b00, "R3");
    tick("R3");

    // R4 / R6: every encoding, full duplex
    full_duplex = 1; runt_accept = 0;
    for (int s = 0; s < 4; s++) begin
      write_wm(2'(s), "R4");
      idle(); frame_start = 1; fifo_count = 0; tick("R6");
      frame_start = 0;
      fifo_count = CNT_W'(thr_of(2'(s)) - 1); tick("R4"); tick("R4");
      fifo_count = CNT_W'(thr_of(2'(s)));     tick("R4"); tick("R4");
      frame_done_ok = 1; tick("R9");
      frame_done_ok = 0; fifo_count = 5; tick("R9");
      drain("R9");
    end

    // R5: half duplex, watermark met early, slot gate holds
    full_duplex = 0; write_wm(2'b00, "R5");
    idle(); frame_start = 1; tick("R5");
    frame_start = 0; fifo_count = 40; rx_byte = 1;
    for (int i = 0; i < 63; i++) tick("R5");
    tick("R5"); rx_byte = 0; tick("R5"); tick("R5");
    frame_done_ok = 1; tick("R9"); drain("R9");

    // R8: runt frame done without runt accept
    idle(); frame_start = 1; tick("R8");
    frame_start = 0; rx_byte = 1; fifo_count = 10;
    for (int i = 0; i < 10; i++) tick("R8");
    rx_byte = 0; frame_done_ok = 1; tick("R8");
    frame_done_ok = 0; tick("R8"); drain("R8");

    // R7: runt accept raises request on short frame
    runt_accept = 1;
    idle(); frame_start = 1; tick("R7");
    frame_start = 0; rx_byte = 1; fifo_count = 3;
    tick("R7"); tick("R7");
    rx_byte = 0; frame_done_ok = 1; tick("R7");
    frame_done_ok = 0; tick("R7"); drain("R9");

    // R10: start and done together, then start clears the count
    runt_accept = 0;
    idle(); frame_start = 1; frame_done_ok = 1; tick("R10");
    frame_start = 0; frame_done_ok = 0; fifo_count = 0; tick("R10");
    rx_byte = 1;
    for (int i = 0; i < 64; i++) tick("R10");
    rx_byte = 0; frame_start = 1; tick("R10");
    frame_start = 0; fifo_count = 50; tick("R10"); tick("R10");
    frame_done_ok = 1; fifo_count = 0; tick("R10");
    drain("R10");

    // seeded random traffic against the cycle model
    for (int c = 0; c < 6000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      frame_start   = (r < 3);
      frame_done_ok = (r >= 3 && r < 6);
      rx_byte       = ($urandom_range(0, 1) == 1);
      ctrl_halted   = ($urandom_range(0, 9) == 0);
      cfg_wr_en     = ($urandom_range(0, 19) == 0);
      cfg_wr_data   = 4'($urandom_range(0, 15));
      if (frame_start) begin
        full_duplex = ($urandom_range(0, 1) == 1);
        runt_accept = ($urandom_range(0, 2) == 0);
      end
      if (m_done) fifo_count = (fifo_count > 8) ? fifo_count - 8 : 0;
      else if (fifo_count < 200) fifo_count = fifo_count + CNT_W'($urandom_range(0, 3));
      tick("R4");
    end

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule